// File: doc/BRIEF.md
# Byte-Serial AES Column Mixer

This block applies the AES column-mixing step to one four-byte state column. The column is fed one byte per clock through an 8-bit input, byte 0 first. A start strobe travels with byte 0, and a direction input chosen at that moment selects either the forward transform or its inverse. Four byte accumulators each add the field product for their own output row as each byte arrives. The four constant products are formed from one shared doubling chain.

Once the fourth byte has been absorbed, the four result bytes appear together on separate 8-bit outputs, and a one-cycle valid flag marks them. The results stay on the outputs until the next start strobe. A round controller places this block between the row-shift stage and the key-mixing stage and reads the result on the valid pulse.

Top module: `byte_mix_col`

## Requirements
- R1: In the forward direction (`inv_i` = 0 at start), result byte i equals the GF(2^8) sum over input bytes j of c[(j - i) mod 4] * b[j], with c = {02, 03, 01, 01}. The field uses the polynomial x^8 + x^4 + x^3 + x + 1, and doubling is a left shift followed by an XOR with 0x1B when the dropped bit is 1. For example, column db 13 53 45 gives 8e 4d a1 bc.
- R2: In the inverse direction (`inv_i` = 1 at start), the same rule applies with c = {0e, 0b, 0d, 09}. Column 8e 4d a1 bc gives db 13 53 45, and any forward result that is fed back through the inverse returns its original column.
- R3: The direction is sampled only in the cycle where `start_i` is high. Changes on `inv_i` during bytes 1 to 3 have no effect on the result.
- R4: When `start_i` is high, the accumulators load fresh products and discard any partial column. A start strobe in the middle of a column restarts the column with the current byte as byte 0.
- R5: `valid_o` is high for exactly one cycle. That cycle directly follows the clock edge that accepts byte 3, and `valid_o` is low in the cycle after any start strobe.
- R6: After a column completes, the result outputs hold their values, and bytes presented without `start_i` are ignored until the next start strobe.
- R7: After a synchronous active-low reset, `valid_o` is 0 and all four result outputs are 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Marks byte 0 of a column |
| inv_i | input | 1 | 1 selects the inverse transform, 0 the forward one; sampled with start |
| byte_i | input | 8 | Column byte, one per clock |
| res0_o | output | 8 | Result byte 0 |
| res1_o | output | 8 | Result byte 1 |
| res2_o | output | 8 | Result byte 2 |
| res3_o | output | 8 | Result byte 3 |
| valid_o | output | 1 | One-cycle pulse when the result bytes are complete |

## Verification
The assertions check the timing properties on every cycle. They confirm that the valid pulse never lasts two cycles, that it never follows a start strobe, that the sequencer is idle whenever the pulse is up, and that the results do not move in the cycle after the pulse unless a new column begins. Only the bench scenarios can show the arithmetic. These cover the known forward and inverse column pair, forward-then-inverse round trips on random columns, a direction flip in mid-column, a restart partway through a column, and idle bytes that must leave the held result alone.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;
  localparam int BYTE_W = 8;
  localparam int N_ROW  = 4;
  localparam int IDX_W  = $clog2(N_ROW);
  localparam logic [BYTE_W-1:0] RED_POLY = 8'h1B;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef byte_t [N_ROW-1:0] col_t;

  // multiply by x in GF(2^8)
  function automatic byte_t gf_dbl(input byte_t a);
    gf_dbl = {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? RED_POLY : '0);
  endfunction
endpackage

// File: rtl/mixcol_gfmul.sv
module mixcol_gfmul
  import mixcol_pkg::*;
(
  input  byte_t x_i,
  input  logic  inv_i,
  output col_t  prod_o   // prod_o[k]: product with coefficient at rotation k
);
  byte_t x2, x4, x8;

  always_comb begin
    x2 = gf_dbl(x_i);
    x4 = gf_dbl(x2);
    x8 = gf_dbl(x4);
    if (inv_i) begin
      prod_o[0] = x8 ^ x4 ^ x2;      // 0e
      prod_o[1] = x8 ^ x2 ^ x_i;     // 0b
      prod_o[2] = x8 ^ x4 ^ x_i;     // 0d
      prod_o[3] = x8 ^ x_i;          // 09
    end else begin
      prod_o[0] = x2;                // 02
      prod_o[1] = x2 ^ x_i;          // 03
      prod_o[2] = x_i;               // 01
      prod_o[3] = x_i;               // 01
    end
  end
endmodule

// File: rtl/mixcol_seq.sv
module mixcol_seq
  import mixcol_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             inv_i,
  output logic             take_o,
  output logic [IDX_W-1:0] pos_o,
  output logic             inv_eff_o,
  output logic             valid_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ROW - 1);

  logic             busy_q, inv_q, valid_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_byte;

  assign take_o    = start_i | busy_q;
  assign pos_o     = start_i ? '0 : idx_q;
  assign inv_eff_o = start_i ? inv_i : inv_q;
  assign last_byte = busy_q & ~start_i & (idx_q == LAST);
  assign valid_o   = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      inv_q   <= 1'b0;
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= last_byte;
      if (start_i) begin
        busy_q <= 1'b1;
        inv_q  <= inv_i;
        idx_q  <= IDX_W'(1);
      end else if (busy_q) begin
        idx_q <= idx_q + IDX_W'(1);
        if (idx_q == LAST) busy_q <= 1'b0;
      end
    end
  end

  // R5
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> !busy_q);
endmodule

// File: rtl/mixcol_acc.sv
module mixcol_acc
  import mixcol_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             first_i,
  input  logic [IDX_W-1:0] pos_i,
  input  col_t             prod_i,
  output col_t             acc_o
);
  col_t acc_q;

  for (genvar g = 0; g < N_ROW; g++) begin : g_row
    localparam logic [IDX_W-1:0] ROW = IDX_W'(g);
    logic [IDX_W-1:0] rot;
    byte_t            term;
    assign rot  = pos_i - ROW;
    assign term = prod_i[rot];

    always_ff @(posedge clk) begin
      if (!rst_n)       acc_q[g] <= '0;
      else if (first_i) acc_q[g] <= term;
      else if (take_i)  acc_q[g] <= acc_q[g] ^ term;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/byte_mix_col.sv
module byte_mix_col
  import mixcol_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       inv_i,
  input  logic [7:0] byte_i,
  output logic [7:0] res0_o,
  output logic [7:0] res1_o,
  output logic [7:0] res2_o,
  output logic [7:0] res3_o,
  output logic       valid_o
);
  logic             take, inv_eff;
  logic [IDX_W-1:0] pos;
  col_t             prod, acc;

  mixcol_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .inv_i(inv_i),
    .take_o(take), .pos_o(pos), .inv_eff_o(inv_eff), .valid_o(valid_o)
  );

  mixcol_gfmul u_mul (.x_i(byte_i), .inv_i(inv_eff), .prod_o(prod));

  mixcol_acc u_acc (
    .clk(clk), .rst_n(rst_n), .take_i(take), .first_i(start_i),
    .pos_i(pos), .prod_i(prod), .acc_o(acc)
  );

  assign res0_o = acc[0];
  assign res1_o = acc[1];
  assign res2_o = acc[2];
  assign res3_o = acc[3];

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R5
  start_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !valid_o);
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !start_i) |=> ($stable(res0_o) && $stable(res1_o) &&
                               $stable(res2_o) && $stable(res3_o)));
endmodule

// File: tb/sim_byte_mix_col.sv
`timescale 1ns/1ps
module sim_byte_mix_col;
  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, inv_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic [7:0] res0_o, res1_o, res2_o, res3_o;
  logic valid_o;
  int n_run = 0, n_fail = 0;
  logic [31:0] seed_v;

  always #4 clk = ~clk;

  byte_mix_col u0 (.clk(clk), .rst_n(rst_n), .start_i(start_i), .inv_i(inv_i),
    .byte_i(byte_i), .res0_o(res0_o), .res1_o(res1_o), .res2_o(res2_o),
    .res3_o(res3_o), .valid_o(valid_o));

  // bench model: shift-and-add field product
  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0, t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= t;
      t = t[7] ? ((t << 1) ^ 8'h1B) : (t << 1);
    end
    return r;
  endfunction

  function automatic logic [31:0] mix(input logic [31:0] col, input logic inv);
    logic [7:0] cf[4];
    logic [31:0] r = 0;
    if (inv) cf = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
    else     cf = '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        r[8*i +: 8] ^= fmul(cf[(j - i + 4) % 4], col[8*j +: 8]);
    return r;
  endfunction

  function automatic logic [31:0] outs();
    return {res3_o, res2_o, res1_o, res0_o};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // feed a column (byte 0 in bits 7:0); flip toggles inv_i after byte 0
  task automatic feed(input logic [31:0] col, input logic inv, input bit flip);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      start_i = (j == 0);
      inv_i   = (j == 0) ? inv : (flip ? ~inv : inv);
      byte_i  = col[8*j +: 8];
    end
    @(negedge clk);
    start_i = 1'b0;
    byte_i  = 8'h00;
  endtask

  task automatic run(input string req, input logic [31:0] col, input logic inv,
                     input bit flip, output logic [31:0] res);
    feed(col, inv, flip);
    chk({req, " valid"}, {31'd0, valid_o}, 32'd1);
    res = outs();
    chk(req, res, mix(col, inv));
  endtask

  initial begin
    logic [31:0] r, r2, hold;
    seed_v = 32'h5eed_1234;
    void'($urandom(seed_v));
    repeat (3) @(negedge clk);
    chk("R7 outs", outs(), 32'h0);
    chk("R7 valid", {31'd0, valid_o}, 32'd0);
    rst_n = 1'b1;

    // R1 known vector db 13 53 45 -> 8e 4d a1 bc
    run("R1", 32'h4553_13db, 1'b0, 1'b0, r);
    chk("R1 vector", r, 32'hbca1_4d8e);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'd0, valid_o}, 32'd0);
    chk("R6 hold", outs(), r);

    // R2 inverse known vector
    run("R2", 32'hbca1_4d8e, 1'b1, 1'b0, r);
    chk("R2 vector", r, 32'h4553_13db);

    // R1 corner columns
    run("R1 zeros", 32'h0000_0000, 1'b0, 1'b0, r);
    run("R1 ones", 32'hffff_ffff, 1'b0, 1'b0, r);
    run("R2 ones", 32'h8080_8080, 1'b1, 1'b0, r);

    // R3 direction flip mid-column ignored
    run("R3 fwd flip", 32'h0a1b_2c3d, 1'b0, 1'b1, r);
    run("R3 inv flip", 32'h0a1b_2c3d, 1'b1, 1'b1, r);

    // R6 idle bytes ignored
    hold = outs();
    repeat (4) begin
      @(negedge clk);
      byte_i = 8'($urandom);
      inv_i  = ~inv_i;
    end
    @(negedge clk);
    chk("R6 idle outs", outs(), hold);
    chk("R6 idle valid", {31'd0, valid_o}, 32'd0);

    // R4 restart mid-column
    @(negedge clk); start_i = 1; inv_i = 0; byte_i = 8'h77;
    @(negedge clk); start_i = 0; byte_i = 8'h99;
    @(negedge clk);
    chk("R5 no valid after start", {31'd0, valid_o}, 32'd0);
    run("R4 restart", 32'hc0ff_ee11, 1'b0, 1'b0, r);

    // R2 random round trips
    for (int n = 0; n < 40; n++) begin
      logic [31:0] c;
      c = $urandom;
      run("R1 rand", c, 1'b0, 1'b0, r);
      run("R2 rand", r, 1'b1, 1'b0, r2);
      chk("R2 round trip", r2, c);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule